// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block watches the address the CPU fetches from and raises a breakpoint request when that address equals a 16-bit value held in two byte-wide registers. Software can also start a break by setting a request bit in the control register. The request is a one-cycle pulse. The CPU uses it to load a software-interrupt opcode into its instruction register. For the break routine, the block supplies the locations of the high and low bytes of the break vector. These locations move to a second pair of addresses while monitor mode is active.

A break-active flag is set when a break is accepted. It stays set until the CPU signals a return-from-interrupt. While the flag is set, the block holds the watchdog off and does not accept another break. A small register bus with a two-bit index, a write enable and combinational read data gives access to the break address and the control bits.

Top module: `addr_break_unit`

## Requirements
- R1: After synchronous active-low reset, every register reads 0, compare is disabled, and `brk_req`, `brk_active` and `wdog_hold` are 0.
- R2: Register index 0 holds the break address high byte and index 1 holds the low byte. Both read back what was last written.
- R3: Index 2 is the control register. Bit 7 enables the compare, bit 6 is the software request, and bit 5 reads the break-active flag. Bits 4..0 read 0, and a write to bit 5 has no effect. Index 3 reads 0 and ignores writes.
- R4: When the compare is enabled and `cpu_fetch` is high in a cycle where `cpu_addr` equals {high byte, low byte}, `brk_req` is 1 for exactly one cycle, starting one clock after that cycle.
- R5: No request is raised when the compare is disabled, when `cpu_fetch` is low, or when any address bit differs.
- R6: Writing 1 to control bit 6 raises `brk_req` one clock after the write edge. Bit 6 reads 0 once the break has been accepted.
- R7: The break-active flag is set in the same edge that raises `brk_req`. It stays set until a cycle with `rti_strobe` high, and the following edge clears it. `rti_strobe` while no break is active changes nothing.
- R8: While the break-active flag is set, address matches do not raise `brk_req`. A software request written during a break stays pending and fires one clock after the break ends.
- R9: `wdog_hold` equals the break-active flag at all times.
- R10: With `monitor_mode` low, `vec_addr_hi` is 16'hFFFC and `vec_addr_lo` is 16'hFFFD. With `monitor_mode` high, they are 16'hFEFC and 16'hFEFD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU-generated fetch address |
| cpu_fetch | input | 1 | High when `cpu_addr` is a program-counter fetch |
| rti_strobe | input | 1 | One-cycle return-from-interrupt indication |
| monitor_mode | input | 1 | Selects the monitor-mode vector locations |
| reg_addr | input | 2 | Register index |
| reg_wr_en | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| brk_req | output | 1 | One-cycle request to force a software-interrupt opcode |
| brk_active | output | 1 | Break in progress |
| wdog_hold | output | 1 | Watchdog disable |
| vec_addr_hi | output | 16 | Location of the break vector high byte |
| vec_addr_lo | output | 16 | Location of the break vector low byte |

## Verification
The assertions assume that `rti_strobe` arrives only as the close of a break. They also assume that no software-request write lands in the same edge that accepts an address-match break; in that one case the request bit stays pending by design. The stimulus pulses `rti_strobe` only after confirming a break is active, except in one deliberate idle pulse. It writes the request bit only while the compare is disabled or a break is already running, and it drops `cpu_fetch` before each return so that no address match is present when the flag clears.

// File: rtl/brk_pkg.sv
// Package: shared register indices and control bit positions for the
// address-match breakpoint controller. Assumes byte-wide registers (>= 8 bits).
package brk_pkg;
    typedef enum logic [1:0] {
        IDX_ADDR_HI = 2'd0,
        IDX_ADDR_LO = 2'd1,
        IDX_CTRL    = 2'd2,
        IDX_SPARE   = 2'd3
    } brk_idx_e;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_SOFT_BIT = 6;
    localparam int CTRL_ACT_BIT  = 5;
endpackage

// File: rtl/brk_regfile.sv
// Module: brk_regfile
// Holds the break address bytes, the compare enable and the software request
// bit, and returns read data for the register bus. Assumes `accept` is high
// only in a cycle where the sequencer takes a break. The active flag is
// owned by the sequencer and is only reflected here.
module brk_regfile #(
    parameter int DATA_W = 8,
    localparam int BADDR_W = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr_en,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               brk_active,
    input  logic               accept,
    output logic [BADDR_W-1:0] brk_addr,
    output logic               cmp_en,
    output logic               soft_req,
    output logic [DATA_W-1:0]  reg_rdata
);
    import brk_pkg::*;

    logic [DATA_W-1:0] addr_hi_q, addr_lo_q;
    logic              en_q, soft_q;
    logic              wr_hi, wr_lo, wr_ctrl, soft_set;

    assign wr_hi    = reg_wr_en && (reg_addr == IDX_ADDR_HI);
    assign wr_lo    = reg_wr_en && (reg_addr == IDX_ADDR_LO);
    assign wr_ctrl  = reg_wr_en && (reg_addr == IDX_CTRL);
    assign soft_set = wr_ctrl && reg_wdata[CTRL_SOFT_BIT];

    // Break address bytes: loaded by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            addr_lo_q <= '0;
        end else begin
            if (wr_hi) addr_hi_q <= reg_wdata;
            if (wr_lo) addr_lo_q <= reg_wdata;
        end
    end

    // Compare enable: follows bit 7 on control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (wr_ctrl) en_q <= reg_wdata[CTRL_EN_BIT];
    end

    // Software request: set by writing 1, cleared when a break is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        soft_q <= 1'b0;
        else if (soft_set) soft_q <= 1'b1;
        else if (accept)   soft_q <= 1'b0;
    end

    // Read mux: index 3 and unused control bits read zero.
    always_comb begin
        reg_rdata = '0;
        unique case (brk_idx_e'(reg_addr))
            IDX_ADDR_HI: reg_rdata = addr_hi_q;
            IDX_ADDR_LO: reg_rdata = addr_lo_q;
            IDX_CTRL: begin
                reg_rdata[CTRL_EN_BIT]   = en_q;
                reg_rdata[CTRL_SOFT_BIT] = soft_q;
                reg_rdata[CTRL_ACT_BIT]  = brk_active;
            end
            IDX_SPARE:   reg_rdata = '0;
        endcase
    end

    assign brk_addr = {addr_hi_q, addr_lo_q};
    assign cmp_en   = en_q;
    assign soft_req = soft_q;

    // R6
    soft_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !soft_set) |=> !soft_req);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hi || wr_lo) |=> $stable(brk_addr));
endmodule

// File: rtl/brk_addr_cmp.sv
// Module: brk_addr_cmp
// Combinational equality compare of the fetch address against the programmed
// break address. Assumes `fetch` marks program-counter addresses only.
module brk_addr_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic              cmp_en,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] brk_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    // Bitwise difference; a hit needs every bit equal.
    always_comb begin
        diff = cpu_addr ^ brk_addr;
        hit  = cmp_en && fetch && (diff == '0);
    end
endmodule

// File: rtl/brk_sequencer.sv
// Module: brk_sequencer
// Accepts a break from an address hit or a pending software request, emits a
// one-cycle request pulse, keeps the break-active flag until return-from-
// interrupt, and selects the vector locations. Assumes `rti` is a single-
// cycle strobe.
module brk_sequencer #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] NORM_VEC = 16'hFFFC,
    parameter logic [ADDR_W-1:0] MON_VEC  = 16'hFEFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              soft_req,
    input  logic              rti,
    input  logic              monitor_mode,
    output logic              accept,
    output logic              brk_req,
    output logic              brk_active,
    output logic [ADDR_W-1:0] vec_hi,
    output logic [ADDR_W-1:0] vec_lo
);
    localparam logic [ADDR_W-1:0] NORM_VEC_LO = NORM_VEC + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] MON_VEC_LO  = MON_VEC + ADDR_W'(1);

    logic req_q, act_q;

    assign accept = (hit || soft_req) && !act_q;

    // Request pulse: one cycle per accepted break.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= accept;
    end

    // Active flag: set on accept, cleared by return-from-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)            act_q <= 1'b0;
        else if (accept)       act_q <= 1'b1;
        else if (act_q && rti) act_q <= 1'b0;
    end

    // Vector locations: monitor mode selects the alternate pair.
    always_comb begin
        vec_hi = monitor_mode ? MON_VEC    : NORM_VEC;
        vec_lo = monitor_mode ? MON_VEC_LO : NORM_VEC_LO;
    end

    assign brk_req    = req_q;
    assign brk_active = act_q;

    // R4
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);

    // R7
    req_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> brk_active);

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !rti) |=> brk_active);

    // R7
    rti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && rti) |=> !brk_active);

    // R8
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && $past(brk_active)) |-> !brk_req);

    // R6
    soft_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_req && !brk_active) |=> brk_req);
endmodule

// File: rtl/addr_break_unit.sv
// Module: addr_break_unit (top)
// Address-match and software-requested breakpoint controller. Ties the
// register file, the address comparator and the break sequencer together.
// Assumes the break address spans exactly two data-width registers.
module addr_break_unit #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_fetch,
    input  logic              rti_strobe,
    input  logic              monitor_mode,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              brk_req,
    output logic              brk_active,
    output logic              wdog_hold,
    output logic [15:0]       vec_addr_hi,
    output logic [15:0]       vec_addr_lo
);
    localparam int BADDR_W = 2 * DATA_W;

    logic [BADDR_W-1:0] brk_addr;
    logic               cmp_en, soft_req, hit, accept;

    initial begin
        if (BADDR_W != ADDR_W || ADDR_W != 16 || DATA_W != 8)
            $error("addr_break_unit: width parameters do not match ports");
    end

    brk_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .brk_active (brk_active),
        .accept     (accept),
        .brk_addr   (brk_addr),
        .cmp_en     (cmp_en),
        .soft_req   (soft_req),
        .reg_rdata  (reg_rdata)
    );

    brk_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .cmp_en   (cmp_en),
        .fetch    (cpu_fetch),
        .cpu_addr (cpu_addr),
        .brk_addr (brk_addr),
        .hit      (hit)
    );

    brk_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .soft_req     (soft_req),
        .rti          (rti_strobe),
        .monitor_mode (monitor_mode),
        .accept       (accept),
        .brk_req      (brk_req),
        .brk_active   (brk_active),
        .vec_hi       (vec_addr_hi),
        .vec_lo       (vec_addr_lo)
    );

    assign wdog_hold = brk_active;

    // R9
    wdog_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_hold) |-> brk_req);

    // R5
    no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_fetch && !soft_req && !brk_active) |=> !brk_req);
endmodule

// File: tb/addr_break_unit_tb_top.sv
module addr_break_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_fetch = 1'b0;
    logic        rti_strobe = 1'b0;
    logic        monitor_mode = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        brk_req, brk_active, wdog_hold;
    logic [15:0] vec_addr_hi, vec_addr_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_break_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch),
        .rti_strobe(rti_strobe), .monitor_mode(monitor_mode),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .brk_req(brk_req), .brk_active(brk_active),
        .wdog_hold(wdog_hold), .vec_addr_hi(vec_addr_hi),
        .vec_addr_lo(vec_addr_lo)
    );

    // Compare table: break address, fetch address, enable, fetch, expected pulse
    localparam int NV = 8;
    localparam logic [34:0] TBL [0:NV-1] = '{
        {16'h1234, 16'h1234, 1'b1, 1'b1, 1'b1},
        {16'h1234, 16'h1235, 1'b1, 1'b1, 1'b0},
        {16'h1234, 16'h1234, 1'b0, 1'b1, 1'b0},
        {16'h1234, 16'h1234, 1'b1, 1'b0, 1'b0},
        {16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1},
        {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1},
        {16'hA55A, 16'h255A, 1'b1, 1'b1, 1'b0},
        {16'h8001, 16'h8000, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic pulse_rti;
        @(negedge clk);
        rti_strobe = 1'b1;
        @(negedge clk);
        rti_strobe = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req", {15'd0, brk_req}, 16'd0);
        chk("R1 active", {15'd0, brk_active}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 hi", 2'd0, 8'h00);
        rd_chk("R1 lo", 2'd1, 8'h00);
        rd_chk("R1 ctrl", 2'd2, 8'h00);
        chk("R9 idle", {15'd0, wdog_hold}, 16'd0);

        // R4 R5: table walk
        for (int i = 0; i < NV; i++) begin
            logic [15:0] ba, ca;
            logic en, fe, ex;
            {ba, ca, en, fe, ex} = TBL[i];
            wr(2'd0, ba[15:8]);
            wr(2'd1, ba[7:0]);
            wr(2'd2, {en, 7'd0});
            @(negedge clk);
            cpu_addr = ca; cpu_fetch = fe;
            @(negedge clk);
            cpu_fetch = 1'b0;
            chk(ex ? "R4 pulse" : "R5 no pulse", {15'd0, brk_req}, {15'd0, ex});
            chk("R7 active", {15'd0, brk_active}, {15'd0, ex});
            chk("R9 wdog", {15'd0, wdog_hold}, {15'd0, ex});
            @(negedge clk);
            chk("R4 single", {15'd0, brk_req}, 16'd0);
            if (ex) begin
                pulse_rti();
                chk("R7 cleared", {15'd0, brk_active}, 16'd0);
                chk("R9 released", {15'd0, wdog_hold}, 16'd0);
            end
        end

        // R2 R3: readback and ignored fields
        wr(2'd0, 8'h5C); wr(2'd1, 8'hE1);
        rd_chk("R2 hi", 2'd0, 8'h5C);
        rd_chk("R2 lo", 2'd1, 8'hE1);
        wr(2'd2, 8'hBF);
        rd_chk("R3 ctrl", 2'd2, 8'h80);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'hFF);
        rd_chk("R3 spare", 2'd3, 8'h00);
        rd_chk("R3 hi kept", 2'd0, 8'h5C);
        rd_chk("R3 ctrl kept", 2'd2, 8'h00);

        // R7: rti while idle has no effect
        pulse_rti();
        chk("R7 idle rti", {15'd0, brk_active}, 16'd0);
        chk("R7 idle rti req", {15'd0, brk_req}, 16'd0);

        // R6: software request
        wr(2'd2, 8'h40);
        chk("R6 not yet", {15'd0, brk_req}, 16'd0);
        @(negedge clk);
        chk("R6 pulse", {15'd0, brk_req}, 16'd1);
        rd_chk("R6 bit cleared", 2'd2, 8'h20);
        pulse_rti();

        // R8: no retrigger during break; pending soft request fires after
        wr(2'd0, 8'h40); wr(2'd1, 8'h10); wr(2'd2, 8'h80);
        @(negedge clk);
        cpu_addr = 16'h4010; cpu_fetch = 1'b1;
        @(negedge clk);
        chk("R8 first", {15'd0, brk_req}, 16'd1);
        repeat (3) begin
            @(negedge clk);
            chk("R8 held off", {15'd0, brk_req}, 16'd0);
        end
        cpu_fetch = 1'b0;
        wr(2'd2, 8'h40);
        @(negedge clk);
        chk("R8 soft pending", {15'd0, brk_req}, 16'd0);
        rd_chk("R8 pending bit", 2'd2, 8'h60);
        pulse_rti();
        chk("R8 gap", {15'd0, brk_req}, 16'd0);
        @(negedge clk);
        chk("R8 fires", {15'd0, brk_req}, 16'd1);
        chk("R9 again", {15'd0, wdog_hold}, 16'd1);
        pulse_rti();

        // R10: vector locations
        monitor_mode = 1'b0; #1;
        chk("R10 norm hi", vec_addr_hi, 16'hFFFC);
        chk("R10 norm lo", vec_addr_lo, 16'hFFFD);
        monitor_mode = 1'b1; #1;
        chk("R10 mon hi", vec_addr_hi, 16'hFEFC);
        chk("R10 mon lo", vec_addr_lo, 16'hFEFD);

        // R1: reset mid-break returns to idle
        wr(2'd2, 8'h40);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset active", {15'd0, brk_active}, 16'd0);
        rd_chk("R1 reset ctrl", 2'd2, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule